// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor that gives each procedure its own window of registers. Eight shared globals sit beside a ring of windows. Each window holds private locals and ins. Its out group is physically the in group of the next window up the ring, so a caller can pass arguments and a callee can return results without copying. Two read ports and one write port take 5-bit architectural register numbers. Each number is translated to a physical entry through the current window pointer.

A save command moves the pointer one window forward and a restore command moves it one back. A counter tracks how many windows currently hold live data. A save that would overrun the oldest live window is refused and raises a spill request. A restore that would step below the oldest live window is refused and raises a fill request. In both cases the pointer is left where it was. A separate transfer port lets an outside agent empty the oldest live window or reload the window just below it, sixteen registers one beat at a time. The agent may repeat transfers as often as it needs before retrying the refused command.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, the resident count is 1, both trap outputs and the transfer busy flag are low, and every register reads 0.
- R2: Architectural register 0 always reads 0, and a write to it has no effect.
- R3: Architectural registers 1 to 7 name one global bank that is the same in every window.
- R4: A write is visible on the read ports from the following cycle. A read in the same cycle returns the old value. The two read ports are independent.
- R5: Register 8+k (out k, k = 0..7) in window w is the same physical entry as register 24+k (in k) in window (w+1) mod NWIN.
- R6: Registers 16 to 23 (locals) and 24 to 31 (ins) belong to their own window. A value written there is seen again whenever the pointer returns to that window.
- R7: A save with resident count below NWIN-1 sets the pointer to (pointer+1) mod NWIN and raises the count by one. A restore with count above 1 sets the pointer to (pointer-1) mod NWIN and lowers the count by one.
- R8: A save with resident count NWIN-1 changes neither pointer nor count, and spill_trap_o is high for exactly the next cycle.
- R9: A restore with resident count 1 changes neither pointer nor count, and fill_trap_o is high for exactly the next cycle.
- R10: A spill start (xfer_start_i with xfer_fill_i=0) is accepted only when the count is at least 2. It targets window (pointer-count+1) mod NWIN. From the next cycle it presents one beat per cycle on xfer_rdata_o with xfer_valid_o, beat k = in k for k<8 and local k-8 for k>=8. xfer_done_o is high with beat 15, after which the count falls by one.
- R11: A fill start (xfer_fill_i=1) is accepted only when the count is below NWIN-1. It targets window (pointer-count) mod NWIN. Each cycle with xfer_wvalid_i high writes the next beat in the same order as R10. xfer_done_o is high with the 16th beat, after which the count rises by one.
- R12: A save and a restore in the same cycle are both ignored. Save and restore are ignored while a transfer is busy. A transfer start in the same cycle as a save or restore is ignored. None of these raises a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | NRD x 5 | Architectural register number per read port |
| rd_data_o | output | NRD x XLEN | Read data per read port |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Architectural register number to write |
| wr_data_i | input | XLEN | Write data |
| save_i | input | 1 | Advance to the next window |
| restore_i | input | 1 | Return to the previous window |
| cwp_o | output | log2(NWIN) | Current window pointer |
| resident_o | output | log2(NWIN) | Number of windows holding live data |
| spill_trap_o | output | 1 | Save refused, oldest window must be spilled |
| fill_trap_o | output | 1 | Restore refused, a window must be filled |
| xfer_start_i | input | 1 | Begin a window transfer |
| xfer_fill_i | input | 1 | Transfer direction: 1 fill, 0 spill |
| xfer_busy_o | output | 1 | Transfer in progress |
| xfer_win_o | output | log2(NWIN) | Window being transferred |
| xfer_idx_o | output | 4 | Beat index within the window |
| xfer_valid_o | output | 1 | Spill beat present on xfer_rdata_o |
| xfer_rdata_o | output | XLEN | Spill beat data |
| xfer_wvalid_i | input | 1 | Fill beat present on xfer_wdata_i |
| xfer_wdata_i | input | XLEN | Fill beat data |
| xfer_done_o | output | 1 | Last beat of the transfer this cycle |

## Verification
The mapping is tried with writes to each register group followed by saves and restores. An out value that turns up as the callee's in shows the overlap. A local that comes back after a round trip shows that windows stay private. A global seen unchanged from another window shows that the bank is shared. Saves are driven until the window ring fills, and past that point, including one save that wraps the pointer from the last window to 0. Restores are driven until a single window is left, and past that point, so refused and accepted commands are told apart by pointer, count and trap pulses. Spills of two different oldest windows and a fill with a stalled beat confirm the target window, the beat order and the count update. Commands issued together, issued during a transfer, or sent to the transfer port in a state where they are not allowed show that they are ignored.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int unsigned ARCH_W = 5;
  localparam int unsigned GRP_SZ = 8;   // registers per group
  localparam int unsigned WIN_SZ = 16;  // private entries per window (ins + locals)
  localparam int unsigned BEAT_W = 4;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SPILL = 2'd1,
    XF_FILL  = 2'd2
  } xfer_state_e;

  // first physical entry of a window's in group
  function automatic int unsigned win_base(input int unsigned w);
    return GRP_SZ + WIN_SZ * w;
  endfunction
endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned WW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [WW-1:0]     cwp_i,
  input  logic [ARCH_W-1:0] arch_i,
  output logic [PW-1:0]     phys_o
);
  reg_grp_e      grp;
  logic [WW-1:0] wsel;

  assign grp = reg_grp_e'(arch_i[4:3]);

  // outs live in the next window's in group
  always_comb begin
    wsel = cwp_i;
    if (grp == GRP_OUT)
      wsel = (cwp_i == WW'(NWIN - 1)) ? '0 : cwp_i + 1'b1;
  end

  always_comb begin
    unique case (grp)
      GRP_GLOBAL: phys_o = PW'(arch_i[2:0]);
      GRP_LOCAL:  phys_o = PW'(win_base(32'(wsel)) + GRP_SZ + 32'(arch_i[2:0]));
      default:    phys_o = PW'(win_base(32'(wsel)) + 32'(arch_i[2:0]));
    endcase
  end
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned WW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic          hold_i,
  input  logic          spill_done_i,
  input  logic          fill_done_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] resident_o,
  output logic          spill_trap_o,
  output logic          fill_trap_o
);
  logic [WW-1:0] cwp_q, res_q;
  logic          spill_q, fill_q;
  logic          cmd_save, cmd_rest, full, single;
  logic [WW-1:0] cwp_up, cwp_dn;

  assign cmd_save = save_i & ~restore_i & ~hold_i;
  assign cmd_rest = restore_i & ~save_i & ~hold_i;
  // one window slot stays free: the top window's outs occupy it
  assign full     = (res_q == WW'(NWIN - 1));
  assign single   = (res_q == WW'(1));
  assign cwp_up   = (cwp_q == WW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
  assign cwp_dn   = (cwp_q == '0) ? WW'(NWIN - 1) : cwp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q   <= '0;
      res_q   <= WW'(1);
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      spill_q <= cmd_save & full;
      fill_q  <= cmd_rest & single;
      if (cmd_save && !full) begin
        cwp_q <= cwp_up;
        res_q <= res_q + 1'b1;
      end else if (cmd_rest && !single) begin
        cwp_q <= cwp_dn;
        res_q <= res_q - 1'b1;
      end else if (spill_done_i) begin
        res_q <= res_q - 1'b1;
      end else if (fill_done_i) begin
        res_q <= res_q + 1'b1;
      end
    end
  end

  assign cwp_o        = cwp_q;
  assign resident_o   = res_q;
  assign spill_trap_o = spill_q;
  assign fill_trap_o  = fill_q;
endmodule

// File: rtl/winreg_xfer.sv
module winreg_xfer
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned WW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fill_i,
  input  logic              cmd_i,
  input  logic [WW-1:0]     cwp_i,
  input  logic [WW-1:0]     resident_i,
  input  logic              wvalid_i,
  output logic              busy_o,
  output logic [WW-1:0]     win_o,
  output logic [BEAT_W-1:0] idx_o,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [PW-1:0]     phys_o,
  output logic              spill_done_o,
  output logic              fill_done_o
);
  xfer_state_e       state_q;
  logic [WW-1:0]     win_q, spill_win, fill_win;
  logic [BEAT_W-1:0] idx_q;
  logic              can_spill, can_fill, accept, beat, last;

  assign can_spill = (resident_i >= WW'(2));
  assign can_fill  = (resident_i != WW'(NWIN - 1));
  assign accept    = (state_q == XF_IDLE) & start_i & ~cmd_i & (fill_i ? can_fill : can_spill);

  // oldest live window, and the one just below it
  assign spill_win = WW'((int'(cwp_i) + int'(NWIN) - int'(resident_i) + 1) % int'(NWIN));
  assign fill_win  = WW'((int'(cwp_i) + int'(NWIN) - int'(resident_i)) % int'(NWIN));

  assign valid_o  = (state_q == XF_SPILL);
  assign wr_en_o  = (state_q == XF_FILL) & wvalid_i;
  assign beat     = valid_o | wr_en_o;
  assign last     = beat & (idx_q == BEAT_W'(WIN_SZ - 1));
  assign busy_o   = (state_q != XF_IDLE);
  assign win_o    = win_q;
  assign idx_o    = idx_q;
  assign phys_o   = PW'(win_base(32'(win_q)) + 32'(idx_q));
  assign spill_done_o = last & valid_o;
  assign fill_done_o  = last & wr_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      win_q   <= '0;
      idx_q   <= '0;
    end else if (state_q == XF_IDLE) begin
      if (accept) begin
        state_q <= fill_i ? XF_FILL : XF_SPILL;
        win_q   <= fill_i ? fill_win : spill_win;
        idx_q   <= '0;
      end
    end else if (beat) begin
      idx_q <= idx_q + 1'b1;
      if (last) state_q <= XF_IDLE;
    end
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned NPHYS = GRP_SZ + WIN_SZ * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS),
  localparam int unsigned WW    = $clog2(NWIN)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NRD-1:0][ARCH_W-1:0]     rd_addr_i,
  output logic [NRD-1:0][XLEN-1:0]       rd_data_o,
  input  logic                           wr_en_i,
  input  logic [ARCH_W-1:0]              wr_addr_i,
  input  logic [XLEN-1:0]                wr_data_i,
  input  logic                           save_i,
  input  logic                           restore_i,
  output logic [WW-1:0]                  cwp_o,
  output logic [WW-1:0]                  resident_o,
  output logic                           spill_trap_o,
  output logic                           fill_trap_o,
  input  logic                           xfer_start_i,
  input  logic                           xfer_fill_i,
  output logic                           xfer_busy_o,
  output logic [WW-1:0]                  xfer_win_o,
  output logic [BEAT_W-1:0]              xfer_idx_o,
  output logic                           xfer_valid_o,
  output logic [XLEN-1:0]                xfer_rdata_o,
  input  logic                           xfer_wvalid_i,
  input  logic [XLEN-1:0]                xfer_wdata_i,
  output logic                           xfer_done_o
);
  logic [XLEN-1:0] mem_q [NPHYS];
  logic [PW-1:0]   wr_phys, xf_phys;
  logic [WW-1:0]   cwp, resident;
  logic            busy, xf_wr, spill_done, fill_done;

  winreg_ctrl #(.NWIN(NWIN), .WW(WW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .hold_i       (busy),
    .spill_done_i (spill_done),
    .fill_done_i  (fill_done),
    .cwp_o        (cwp),
    .resident_o   (resident),
    .spill_trap_o (spill_trap_o),
    .fill_trap_o  (fill_trap_o)
  );

  winreg_xfer #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (xfer_start_i),
    .fill_i       (xfer_fill_i),
    .cmd_i        (save_i | restore_i),
    .cwp_i        (cwp),
    .resident_i   (resident),
    .wvalid_i     (xfer_wvalid_i),
    .busy_o       (busy),
    .win_o        (xfer_win_o),
    .idx_o        (xfer_idx_o),
    .valid_o      (xfer_valid_o),
    .wr_en_o      (xf_wr),
    .phys_o       (xf_phys),
    .spill_done_o (spill_done),
    .fill_done_o  (fill_done)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [PW-1:0] rd_phys;
    winreg_xlate #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_rd_xlate (
      .cwp_i  (cwp),
      .arch_i (rd_addr_i[g]),
      .phys_o (rd_phys)
    );
    // entry 0 is never written, so register 0 reads zero
    assign rd_data_o[g] = mem_q[rd_phys];
  end

  winreg_xlate #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_wr_xlate (
    .cwp_i  (cwp),
    .arch_i (wr_addr_i),
    .phys_o (wr_phys)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHYS); i++) mem_q[i] <= '0;
    end else begin
      if (wr_en_i && wr_addr_i != '0) mem_q[wr_phys] <= wr_data_i;
      // a fill only touches a non-resident window
      if (xf_wr) mem_q[xf_phys] <= xfer_wdata_i;
    end
  end

  assign xfer_rdata_o = mem_q[xf_phys];
  assign xfer_busy_o  = busy;
  assign xfer_done_o  = spill_done | fill_done;
  assign cwp_o        = cwp;
  assign resident_o   = resident;
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned WW  = $clog2(NWIN)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NRD-1:0][ARCH_W-1:0] rd_addr_i,
  input logic [NRD-1:0][XLEN-1:0]   rd_data_o,
  input logic                       save_i,
  input logic                       restore_i,
  input logic [WW-1:0]              cwp_o,
  input logic [WW-1:0]              resident_o,
  input logic                       spill_trap_o,
  input logic                       fill_trap_o,
  input logic                       xfer_busy_o,
  input logic                       xfer_valid_o,
  input logic                       xfer_done_o
);
  assert_zero_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i[0] == '0 |-> rd_data_o[0] == '0);

  assert_res_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resident_o != '0 && resident_o <= WW'(NWIN - 1));

  assert_save_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i && !restore_i && !xfer_busy_o && resident_o != WW'(NWIN - 1)
    |=> resident_o == $past(resident_o) + 1'b1);

  assert_spill_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_trap_o |-> $past(save_i) && $past(resident_o) == WW'(NWIN - 1));

  assert_spill_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_trap_o |-> cwp_o == $past(cwp_o) && resident_o == $past(resident_o));

  assert_fill_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trap_o |-> $past(restore_i) && $past(resident_o) == WW'(1));

  assert_fill_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trap_o |-> cwp_o == $past(cwp_o));

  assert_spill_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o && xfer_valid_o |=> resident_o == $past(resident_o) - 1'b1);

  assert_fill_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o && !xfer_valid_o |=> resident_o == $past(resident_o) + 1'b1);

  assert_busy_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_busy_o && !xfer_done_o |=> $stable(cwp_o));

  assert_trap_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({spill_trap_o, fill_trap_o}));
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) u_chk (.*);

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int NRD  = 2;
  localparam int WW   = 3;
  localparam int NV   = 19;

  // {cmd[44:43] 1=save 2=restore, we[42], waddr[41:37], wdata[36:21], raddr[20:16], exp[15:0]}
  localparam logic [44:0] VEC [NV] = '{
    {2'd0, 1'b1, 5'd1,  16'h1111, 5'd1,  16'h0000},
    {2'd0, 1'b1, 5'd8,  16'h0808, 5'd1,  16'h1111},
    {2'd0, 1'b1, 5'd16, 16'h1616, 5'd8,  16'h0808},
    {2'd0, 1'b1, 5'd24, 16'h2424, 5'd16, 16'h1616},
    {2'd1, 1'b0, 5'd0,  16'h0000, 5'd24, 16'h2424},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd24, 16'h0808},
    {2'd0, 1'b1, 5'd16, 16'h7777, 5'd16, 16'h0000},
    {2'd0, 1'b1, 5'd8,  16'h0A0A, 5'd16, 16'h7777},
    {2'd2, 1'b0, 5'd0,  16'h0000, 5'd1,  16'h1111},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd16, 16'h1616},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd8,  16'h0808},
    {2'd0, 1'b1, 5'd0,  16'hDEAD, 5'd0,  16'h0000},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd0,  16'h0000},
    {2'd1, 1'b0, 5'd0,  16'h0000, 5'd24, 16'h2424},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd16, 16'h7777},
    {2'd1, 1'b0, 5'd0,  16'h0000, 5'd8,  16'h0A0A},
    {2'd0, 1'b0, 5'd0,  16'h0000, 5'd24, 16'h0A0A},
    {2'd2, 1'b0, 5'd0,  16'h0000, 5'd1,  16'h1111},
    {2'd2, 1'b0, 5'd0,  16'h0000, 5'd24, 16'h0808}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 2, 3:        return "R4";
      1, 8, 17:       return "R3";
      4, 13:          return "R7";
      5, 10, 15, 16, 18: return "R5";
      11, 12:         return "R2";
      default:        return "R6";
    endcase
  endfunction

  logic                       clk_i = 1'b0;
  logic                       rst_ni;
  logic [NRD-1:0][4:0]        rd_addr_i;
  logic [NRD-1:0][XLEN-1:0]   rd_data_o;
  logic                       wr_en_i;
  logic [4:0]                 wr_addr_i;
  logic [XLEN-1:0]            wr_data_i;
  logic                       save_i, restore_i;
  logic [WW-1:0]              cwp_o, resident_o;
  logic                       spill_trap_o, fill_trap_o;
  logic                       xfer_start_i, xfer_fill_i, xfer_busy_o;
  logic [WW-1:0]              xfer_win_o;
  logic [3:0]                 xfer_idx_o;
  logic                       xfer_valid_o;
  logic [XLEN-1:0]            xfer_rdata_o;
  logic                       xfer_wvalid_i;
  logic [XLEN-1:0]            xfer_wdata_i;
  logic                       xfer_done_o;

  int n_vec = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  winreg_file #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_cmd(input logic s, input logic r);
    save_i = s; restore_i = r;
    tick();
    save_i = 1'b0; restore_i = 1'b0;
  endtask

  task automatic run_spill(input logic [WW-1:0] exp_win, input logic [31:0] exp_b0,
                           input logic [31:0] exp_b8);
    logic [31:0] b0, b8;
    int beats;
    bit done_seen;
    b0 = 'x; b8 = 'x; beats = 0; done_seen = 0;
    xfer_start_i = 1'b1; xfer_fill_i = 1'b0;
    tick();
    xfer_start_i = 1'b0;
    chk("R10 spill window", 32'(xfer_win_o), 32'(exp_win));
    for (int c = 0; c < 24 && !done_seen; c++) begin
      if (xfer_valid_o) begin
        if (xfer_idx_o == 4'd0) b0 = xfer_rdata_o;
        if (xfer_idx_o == 4'd8) b8 = xfer_rdata_o;
        beats++;
        if (xfer_done_o) begin
          done_seen = 1;
          chk("R10 done with beat 15", 32'(xfer_idx_o), 32'd15);
        end
      end
      save_i = (c == 3);  // R12: ignored while busy
      tick();
    end
    save_i = 1'b0;
    chk("R10 spill beat count", 32'(beats), 32'd16);
    chk("R10 spill beat 0 (in 0)", b0, exp_b0);
    chk("R10 spill beat 8 (local 0)", b8, exp_b8);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_vec++; n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    rd_addr_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    save_i = 1'b0; restore_i = 1'b0;
    xfer_start_i = 1'b0; xfer_fill_i = 1'b0; xfer_wvalid_i = 1'b0; xfer_wdata_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 cwp", 32'(cwp_o), 32'd0);
    chk("R1 resident", 32'(resident_o), 32'd1);
    chk("R1 traps", {30'd0, spill_trap_o, fill_trap_o}, 32'd0);
    chk("R1 busy", 32'(xfer_busy_o), 32'd0);
    rd_addr_i[0] = 5'd24; rd_addr_i[1] = 5'd5;
    #1;
    chk("R1 r24 zero", rd_data_o[0], 32'd0);
    chk("R1 r5 zero", rd_data_o[1], 32'd0);
    tick();

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      save_i    = (v[44:43] == 2'd1);
      restore_i = (v[44:43] == 2'd2);
      wr_en_i   = v[42];
      wr_addr_i = v[41:37];
      wr_data_i = {16'h0, v[36:21]};
      rd_addr_i[0] = v[20:16];
      #1;
      chk($sformatf("%s vector %0d", vtag(i), i), rd_data_o[0], {16'h0, v[15:0]});
      tick();
    end
    save_i = 1'b0; restore_i = 1'b0; wr_en_i = 1'b0;

    // R4 both ports, same-cycle write not visible
    wr_en_i = 1'b1; wr_addr_i = 5'd2; wr_data_i = 32'h2222;
    rd_addr_i[0] = 5'd2; rd_addr_i[1] = 5'd1;
    #1;
    chk("R4 port0 same cycle old", rd_data_o[0], 32'd0);
    chk("R4 port1 independent", rd_data_o[1], 32'h1111);
    tick();
    wr_en_i = 1'b0;
    rd_addr_i[1] = 5'd2;
    #1;
    chk("R4 port0 next cycle", rd_data_o[0], 32'h2222);
    chk("R4 port1 next cycle", rd_data_o[1], 32'h2222);

    // R12 save and restore together
    do_cmd(1'b1, 1'b1);
    chk("R12 both ignored cwp", 32'(cwp_o), 32'd0);
    chk("R12 both ignored res", 32'(resident_o), 32'd1);
    chk("R12 no trap", {30'd0, spill_trap_o, fill_trap_o}, 32'd0);

    // R7 fill the ring
    for (int k = 0; k < NWIN - 2; k++) do_cmd(1'b1, 1'b0);
    chk("R7 cwp after saves", 32'(cwp_o), 32'd6);
    chk("R7 resident full", 32'(resident_o), 32'd7);

    // R8 refused save
    do_cmd(1'b1, 1'b0);
    chk("R8 spill trap", 32'(spill_trap_o), 32'd1);
    chk("R8 cwp held", 32'(cwp_o), 32'd6);
    chk("R8 resident held", 32'(resident_o), 32'd7);
    tick();
    chk("R8 trap one cycle", 32'(spill_trap_o), 32'd0);

    // R11 fill refused when full
    xfer_start_i = 1'b1; xfer_fill_i = 1'b1;
    tick();
    xfer_start_i = 1'b0; xfer_fill_i = 1'b0;
    chk("R11 fill refused when full", 32'(xfer_busy_o), 32'd0);

    // R10 spill oldest (window 0), then save proceeds
    run_spill(3'd0, 32'h2424, 32'h1616);
    chk("R10 resident after spill", 32'(resident_o), 32'd6);
    chk("R12 save during spill ignored", 32'(cwp_o), 32'd6);
    do_cmd(1'b1, 1'b0);
    chk("R7 save after spill", 32'(cwp_o), 32'd7);

    // second spill (window 1: in 0 is window 0's out 0)
    run_spill(3'd1, 32'h0808, 32'h7777);
    do_cmd(1'b1, 1'b0);
    chk("R7 pointer wraps", 32'(cwp_o), 32'd0);
    chk("R7 resident after wrap", 32'(resident_o), 32'd7);

    // R7 restores down to one window
    for (int k = 0; k < NWIN - 2; k++) do_cmd(1'b0, 1'b1);
    chk("R7 cwp after restores", 32'(cwp_o), 32'd2);
    chk("R7 resident single", 32'(resident_o), 32'd1);

    // R9 refused restore
    do_cmd(1'b0, 1'b1);
    chk("R9 fill trap", 32'(fill_trap_o), 32'd1);
    chk("R9 cwp held", 32'(cwp_o), 32'd2);
    chk("R9 resident held", 32'(resident_o), 32'd1);

    // R10 spill refused with one window
    xfer_start_i = 1'b1; xfer_fill_i = 1'b0;
    tick();
    xfer_start_i = 1'b0;
    chk("R10 spill refused single", 32'(xfer_busy_o), 32'd0);

    // R12 start with a save is ignored
    xfer_start_i = 1'b1; xfer_fill_i = 1'b1; save_i = 1'b1;
    tick();
    xfer_start_i = 1'b0; save_i = 1'b0;
    chk("R12 start with save ignored", 32'(xfer_busy_o), 32'd0);
    do_cmd(1'b0, 1'b1);  // back to cwp 2 (save above advanced to 3)
    chk("R12 pointer back", 32'(cwp_o), 32'd2);

    // R11 fill window 1 with a stall
    xfer_start_i = 1'b1; xfer_fill_i = 1'b1;
    tick();
    xfer_start_i = 1'b0; xfer_fill_i = 1'b0;
    chk("R11 fill window", 32'(xfer_win_o), 32'd1);
    begin
      int k;
      k = 0;
      for (int c = 0; c < 24 && k < 16; c++) begin
        xfer_wvalid_i = (c != 5);
        xfer_wdata_i  = 32'hF000 + 32'(k);
        #1;
        if (k == 15 && xfer_wvalid_i) chk("R11 done with 16th beat", 32'(xfer_done_o), 32'd1);
        else if (k == 14) chk("R11 no early done", 32'(xfer_done_o), 32'd0);
        tick();
        if (xfer_wvalid_i) k++;
      end
      xfer_wvalid_i = 1'b0;
    end
    chk("R11 resident after fill", 32'(resident_o), 32'd2);
    do_cmd(1'b0, 1'b1);
    chk("R11 restore into filled", 32'(cwp_o), 32'd1);
    rd_addr_i[0] = 5'd24; rd_addr_i[1] = 5'd31;
    #1;
    chk("R11 filled in 0", rd_data_o[0], 32'hF000);
    chk("R11 filled in 7", rd_data_o[1], 32'hF007);
    rd_addr_i[0] = 5'd16;
    #1;
    chk("R11 filled local 0", rd_data_o[0], 32'hF008);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule